// File: doc/BRIEF.md
# Data Separator Phase Comparator

This block is the phase detector of a floppy read-data separator. A fast sampling clock observes the raw, active-low read-data stream from the drive and the recovered-clock window signal from the VCO. Every transition of the window signal, in either direction, opens a new window. The block counts sampling ticks from that opening. When a read-data pulse begins, which is the falling edge of the active-low line, the block notes the tick count and sorts the pulse into one of three regions: early, center or late.

An early pulse asks the VCO to run faster. The up line drives a logic 1 for a fixed number of sampling cycles. A late pulse asks the VCO to slow down, so the active-low down line drives a logic 0 for the same time. A pulse in the center region is a dead zone: both lines stay high-impedance and any request still running is cancelled. Each line is given as an output-enable, and the driven value is fixed by which line it is. A combined adjust line is also provided, shaped like the two lines tied together: high to speed up, low to slow down, floating to hold.

The comparator works only while clock recovery is enabled. That needs both the write gate and the VFO-off/write-fault input to be low. While either one is high, both lines float at once and no pulse is acted on. The nominal recovered clock is 2 MHz. With the default of 16 ticks per window half-period, this implies a 64 MHz sampling clock.

Top module: `dsep_phase_cmp`

## Requirements
- R1: While reset is held, and after reset with no read-data pulse, up_oe, dn_oe and adj_oe are all 0.
- R2: A falling edge of rd_data_n at tick 0..EARLY_TICKS-1 (default 0..3) of the current window sets up_oe to 1 and keeps dn_oe at 0. With SYNC_STAGES=2, up_oe first reads 1 after the third rising clk edge that follows the rd_data_n change.
- R3: A falling edge at tick LATE_START or later (default 12 and above) sets dn_oe to 1 and keeps up_oe at 0, with the same latency as R2.
- R4: A falling edge at a tick from EARLY_TICKS to LATE_START-1 (default 4..11) raises neither output, and cancels any request that is still active, in the same cycle that a new request would load.
- R5: A request stays asserted for exactly HOLD_CYCLES clk cycles (default 6) and then returns to 0, provided no new pulse arrives first.
- R6: Only the falling edge of rd_data_n is compared. A rising edge, or a line held low, starts no request.
- R7: When wr_gate or vfo_off is 1, up_oe, dn_oe and adj_oe are 0 in that same cycle. Any request pending is discarded, and read-data edges seen while disabled produce no request afterwards.
- R8: adj_oe is 1 exactly when one request is active. adj_val is 1 for an up request and 0 for a down request. up_oe and dn_oe are never 1 together.
- R9: Each transition of rclk_win (rising or falling) restarts the window. A read-data edge that arrives in the same sampling cycle as a window transition is at tick 0, and so is early.
- R10: The tick count saturates at 2*WIN_TICKS-1 and stays there. A pulse after a long stretch with no window transitions is judged late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_gate | input | 1 | Write gate; 1 disables the comparator |
| vfo_off | input | 1 | VFO-off / write-fault; 1 disables the comparator |
| rd_data_n | input | 1 | Raw read data from the drive, active low, asynchronous |
| rclk_win | input | 1 | Recovered-clock window signal, asynchronous |
| up_oe | output | 1 | Enable of the up line; when 1 the line drives logic 1 |
| dn_oe | output | 1 | Enable of the active-low down line; when 1 the line drives logic 0 |
| adj_oe | output | 1 | Enable of the combined adjust line |
| adj_val | output | 1 | Value driven on the combined adjust line when adj_oe is 1 |

## Verification
On every cycle, the assertions check the following: the two requests never overlap, a disabled comparator leaves no hold counter loaded, each counter counts down by one per cycle, the early and late regions load the proper counter while the center region clears both, the window counter restarts and saturates as it should, and a detected falling edge lasts one cycle only. Some behaviour only the directed scenarios can show. These are the exact latency from the pin to the output, the tick boundaries between regions, the length of the hold seen from outside, a center pulse cutting short a running request, and edges ignored during a disable leaving nothing behind once it lifts.

// File: rtl/dsep_pkg.sv
// Package: dsep_pkg
// Shared types for the data separator phase comparator.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package dsep_pkg;

    // Region of the recovered-clock window in which a read-data edge fell.
    typedef enum logic [1:0] {
        PH_CENTER = 2'd0,
        PH_EARLY  = 2'd1,
        PH_LATE   = 2'd2
    } phase_e;

    // Which kind of transition an edge synchronizer reports.
    typedef enum logic {
        EV_FALL = 1'b0,
        EV_ANY  = 1'b1
    } edge_kind_e;

endpackage

// File: rtl/dsep_edge_sync.sv
// Module: dsep_edge_sync
// Brings one asynchronous input into the clk domain through a chain of
// STAGES flops. It then flags, for a single cycle, either a falling edge
// or any transition, as KIND selects.
// Assumes: the input stays stable for at least one clk period between
// changes. INIT is the line's idle level, loaded during reset so that
// leaving reset does not raise a false event.
module dsep_edge_sync
    import dsep_pkg::*;
#(
    parameter int         STAGES = 2,
    parameter logic       INIT   = 1'b1,
    parameter edge_kind_e KIND   = EV_FALL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic event_o
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // First synchronizer stage captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= INIT;
        else        chain[0] <= din;
    end

    // Remaining stages settle metastability.
    for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[gi] <= INIT;
            else        chain[gi] <= chain[gi-1];
        end
    end

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= INIT;
        else        prev <= chain[STAGES-1];
    end

    // Event decode picked at elaboration.
    if (KIND == EV_FALL) begin : g_fall
        assign event_o = prev & ~chain[STAGES-1];
    end else begin : g_any
        assign event_o = prev ^ chain[STAGES-1];
    end

    // R6: an event cannot repeat on the next cycle without a new change.
    a_r6_single_cycle_event: assert property (@(posedge clk) disable iff (!rst_n)
        (KIND == EV_FALL && event_o) |=> !event_o);

endmodule

// File: rtl/dsep_window_timer.sv
// Module: dsep_window_timer
// Counts sampling ticks since the last window transition and sorts the
// current tick into the early, center or late region.
// Assumes: 0 < EARLY_TICKS <= LATE_START < 2*WIN_TICKS. The cycle in which
// win_edge is high is tick 0. The count saturates, and a window never
// opened (as after reset) reads as late.
module dsep_window_timer
    import dsep_pkg::*;
#(
    parameter int WIN_TICKS   = 16,
    parameter int EARLY_TICKS = WIN_TICKS / 4,
    parameter int LATE_START  = WIN_TICKS - WIN_TICKS / 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   win_edge,
    output phase_e phase
);

    localparam int CNT_W = $clog2(2 * WIN_TICKS);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] EARLY_LIM = CNT_W'(EARLY_TICKS);
    localparam logic [CNT_W-1:0] LATE_LIM  = CNT_W'(LATE_START);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tick;

    // Current tick: zero on a window transition, else the stored count.
    always_comb begin
        tick = win_edge ? '0 : cnt_q;
    end

    // Advance the count with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= CNT_MAX;
        else if (tick == CNT_MAX) cnt_q <= CNT_MAX;
        else                      cnt_q <= tick + CNT_W'(1);
    end

    // Region decision for the current tick.
    always_comb begin
        if (tick < EARLY_LIM)      phase = PH_EARLY;
        else if (tick >= LATE_LIM) phase = PH_LATE;
        else                       phase = PH_CENTER;
    end

    // R9: a window transition restarts the count.
    a_r9_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
        win_edge |=> (cnt_q == CNT_W'(1)));

    // R10: the count holds at its ceiling while no window transition comes.
    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !win_edge) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/dsep_pump_ctrl.sv
// Module: dsep_pump_ctrl
// Turns a classified read-data edge into a timed up or down request. Each
// request lives in its own down-counter. A new edge replaces whatever is
// running, and a disable clears both counters.
// Assumes: strobe is a single-cycle pulse. phase is valid whenever strobe
// is high.
module dsep_pump_ctrl
    import dsep_pkg::*;
#(
    parameter int HOLD_CYCLES = 6
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   strobe,
    input  phase_e phase,
    output logic   up_oe,
    output logic   dn_oe
);

    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYCLES);

    logic [HW-1:0] up_cnt;
    logic [HW-1:0] dn_cnt;

    // Load, cancel or count down the two request timers.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            up_cnt <= '0;
            dn_cnt <= '0;
        end else if (strobe) begin
            unique case (phase)
                PH_EARLY: begin up_cnt <= HOLD_V; dn_cnt <= '0;     end
                PH_LATE:  begin up_cnt <= '0;     dn_cnt <= HOLD_V; end
                default:  begin up_cnt <= '0;     dn_cnt <= '0;     end
            endcase
        end else begin
            if (up_cnt != '0) up_cnt <= up_cnt - HW'(1);
            if (dn_cnt != '0) dn_cnt <= dn_cnt - HW'(1);
        end
    end

    // Output enables, forced off at once while disabled.
    always_comb begin
        up_oe = en && (up_cnt != '0);
        dn_oe = en && (dn_cnt != '0);
    end

    // R2: an early edge loads the up timer and clears the down timer.
    a_r2_early_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe && phase == PH_EARLY) |=> (up_cnt == HOLD_V && dn_cnt == '0));

    // R3: a late edge loads the down timer and clears the up timer.
    a_r3_late_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe && phase == PH_LATE) |=> (dn_cnt == HOLD_V && up_cnt == '0));

    // R4: a center edge leaves no request running.
    a_r4_center_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe && phase == PH_CENTER) |=> (up_cnt == '0 && dn_cnt == '0));

    // R5: a running up request shortens by one each cycle.
    a_r5_up_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !strobe && up_cnt != '0) |=> (up_cnt == $past(up_cnt) - HW'(1)));

    // R5: a running down request shortens by one each cycle.
    a_r5_dn_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !strobe && dn_cnt != '0) |=> (dn_cnt == $past(dn_cnt) - HW'(1)));

    // R7: a disable leaves nothing pending.
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (up_cnt == '0 && dn_cnt == '0));

    // R8: the two timers never run together.
    a_r8_timers_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_cnt != '0 && dn_cnt != '0));

endmodule

// File: rtl/dsep_phase_cmp.sv
// Module: dsep_phase_cmp (top)
// Phase comparator of a floppy read-data separator. It synchronizes the
// read data and the recovered-clock window, times each read-data leading
// edge within the window, and issues up, down or no request as
// output-enables of three-state style lines.
// Assumes: clk is much faster than the window (WIN_TICKS ticks for each
// half-period). Both asynchronous inputs pass through equal-length
// synchronizers, so their timing relative to each other is kept.
module dsep_phase_cmp
    import dsep_pkg::*;
#(
    parameter int WIN_TICKS   = 16,
    parameter int EARLY_TICKS = WIN_TICKS / 4,
    parameter int LATE_START  = WIN_TICKS - WIN_TICKS / 4,
    parameter int HOLD_CYCLES = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_gate,
    input  logic vfo_off,
    input  logic rd_data_n,
    input  logic rclk_win,
    output logic up_oe,
    output logic dn_oe,
    output logic adj_oe,
    output logic adj_val
);

    logic   rd_fall;
    logic   win_edge;
    logic   en;
    phase_e phase;

    // Clock recovery runs only while neither gate input is active.
    always_comb begin
        en = !wr_gate && !vfo_off;
    end

    dsep_edge_sync #(
        .STAGES (SYNC_STAGES),
        .INIT   (1'b1),
        .KIND   (EV_FALL)
    ) u_rd_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (rd_data_n),
        .event_o (rd_fall)
    );

    dsep_edge_sync #(
        .STAGES (SYNC_STAGES),
        .INIT   (1'b0),
        .KIND   (EV_ANY)
    ) u_win_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (rclk_win),
        .event_o (win_edge)
    );

    dsep_window_timer #(
        .WIN_TICKS   (WIN_TICKS),
        .EARLY_TICKS (EARLY_TICKS),
        .LATE_START  (LATE_START)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_edge (win_edge),
        .phase    (phase)
    );

    dsep_pump_ctrl #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_pump (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .strobe (rd_fall),
        .phase  (phase),
        .up_oe  (up_oe),
        .dn_oe  (dn_oe)
    );

    // Combined adjust line, as if the two lines were tied together.
    always_comb begin
        adj_oe  = up_oe | dn_oe;
        adj_val = up_oe;
    end

    // R8: the two line enables never overlap at the ports.
    a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_oe && dn_oe));

    // R7: a disabled comparator drives nothing.
    a_r7_float_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate || vfo_off) |-> !adj_oe);

endmodule

// File: tb/dsep_phase_cmp_tb.sv
module dsep_phase_cmp_tb;

    localparam time CLK_PERIOD = 16ns;
    localparam int  HOLD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_gate = 1'b0;
    logic vfo_off = 1'b0;
    logic rd_data_n = 1'b1;
    logic rclk_win = 1'b0;
    logic up_oe, dn_oe, adj_oe, adj_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dsep_phase_cmp u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_gate   (wr_gate),
        .vfo_off   (vfo_off),
        .rd_data_n (rd_data_n),
        .rclk_win  (rclk_win),
        .up_oe     (up_oe),
        .dn_oe     (dn_oe),
        .adj_oe    (adj_oe),
        .adj_val   (adj_val)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Hold read data idle for n falling clock edges.
    task automatic idle(input int n);
        rd_data_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // Open a window (optionally), then drop read data k ticks later.
    task automatic fire(input int k, input bit toggle);
        @(negedge clk);
        if (toggle) rclk_win = ~rclk_win;
        repeat (k) @(negedge clk);
        rd_data_n = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "up_oe in reset", up_oe, 1'b0);
        chk("R1", "dn_oe in reset", dn_oe, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "up_oe after reset", up_oe, 1'b0);
        chk("R1", "dn_oe after reset", dn_oe, 1'b0);
        chk("R1", "adj_oe after reset", adj_oe, 1'b0);
    endtask

    // One pulse at tick k; checks the request three edges later.
    task automatic t_phase(input int k, input logic eu, input logic ed, input string req);
        idle(HOLD + 6);
        fire(k, 1'b1);
        repeat (2) @(negedge clk);
        chk(req, "up_oe before latency", up_oe, 1'b0);
        chk(req, "dn_oe before latency", dn_oe, 1'b0);
        @(negedge clk);
        chk(req, "up_oe", up_oe, eu);
        chk(req, "dn_oe", dn_oe, ed);
        chk("R8", "adj_oe", adj_oe, eu | ed);
        if (eu | ed) chk("R8", "adj_val", adj_val, eu);
        rd_data_n = 1'b1;
    endtask

    task automatic t_hold();
        idle(HOLD + 6);
        fire(1, 1'b1);
        repeat (2) @(negedge clk);
        chk("R5", "up_oe before start", up_oe, 1'b0);
        for (int i = 0; i < HOLD; i++) begin
            @(negedge clk);
            chk("R5", "up_oe during hold", up_oe, 1'b1);
        end
        @(negedge clk);
        chk("R5", "up_oe after hold", up_oe, 1'b0);
        rd_data_n = 1'b1;
    endtask

    task automatic t_rise_ignored();
        idle(HOLD + 6);
        fire(1, 1'b1);
        repeat (HOLD + 8) @(negedge clk);
        chk("R6", "no repeat while held low", up_oe | dn_oe, 1'b0);
        rclk_win = ~rclk_win;
        @(negedge clk);
        rd_data_n = 1'b1;
        for (int i = 0; i < HOLD; i++) begin
            @(negedge clk);
            chk("R6", "rising edge ignored", adj_oe, 1'b0);
        end
    endtask

    task automatic t_center_cancels();
        idle(HOLD + 6);
        fire(1, 1'b1);
        @(negedge clk);
        rd_data_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "first early request", up_oe, 1'b1);
        rd_data_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4", "request still running", up_oe, 1'b1);
        @(negedge clk);
        chk("R4", "center cancels up", up_oe, 1'b0);
        chk("R4", "center raises no down", dn_oe, 1'b0);
        rd_data_n = 1'b1;
    endtask

    task automatic t_disable_wg();
        idle(HOLD + 6);
        fire(1, 1'b1);
        repeat (3) @(negedge clk);
        chk("R7", "up_oe before gate", up_oe, 1'b1);
        wr_gate = 1'b1;
        #1;
        chk("R7", "up_oe floats with gate", up_oe, 1'b0);
        chk("R7", "adj_oe floats with gate", adj_oe, 1'b0);
        @(negedge clk);
        wr_gate = 1'b0;
        #1;
        chk("R7", "pending request discarded", up_oe, 1'b0);
        rd_data_n = 1'b1;
    endtask

    task automatic t_disable_vfo();
        idle(HOLD + 6);
        vfo_off = 1'b1;
        fire(13, 1'b1);
        repeat (3) @(negedge clk);
        chk("R7", "dn_oe while vfo_off", dn_oe, 1'b0);
        @(negedge clk);
        vfo_off = 1'b0;
        #1;
        chk("R7", "dn_oe after vfo_off lifts", dn_oe, 1'b0);
        repeat (3) @(negedge clk);
        chk("R7", "no late request appears", adj_oe, 1'b0);
        rd_data_n = 1'b1;
    endtask

    task automatic t_saturate();
        idle(80);
        fire(0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10", "dn_oe after long gap", dn_oe, 1'b1);
        chk("R10", "up_oe after long gap", up_oe, 1'b0);
        chk("R8", "adj_val drives low", adj_val, 1'b0);
        rd_data_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_phase(0, 1'b1, 1'b0, "R9");
        t_phase(2, 1'b1, 1'b0, "R2");
        t_phase(3, 1'b1, 1'b0, "R2");
        t_phase(4, 1'b0, 1'b0, "R4");
        t_phase(11, 1'b0, 1'b0, "R4");
        t_phase(12, 1'b0, 1'b1, "R3");
        t_phase(15, 1'b0, 1'b1, "R3");
        t_hold();
        t_rise_ignored();
        t_center_cancels();
        t_disable_wg();
        t_disable_vfo();
        t_saturate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule